// File: doc/BRIEF.md
# UART Modem Control and Status Register Pair

This block holds the modem-side registers of a 16550-style serial port: a five-bit control register that drives the four handshake output pins and selects internal loopback, and an eight-bit status register. The status register reports the present level of four modem inputs and keeps sticky flags that record how they have changed. A host reaches both registers through a byte-wide read/write port with a one-bit register select. The interrupt-source output stays high while any change flag is pending, so an interrupt controller can decide priority elsewhere.

The four modem inputs are asynchronous. Each one passes through a synchronizer chain of `SYNC_STAGES` flops before the change detector compares it with the stored level. In loopback, a status read shows the control bits, cross-wired onto the status positions, in place of the pins. In that mode, control writes leave the real output pins alone.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset, the control register reads 0x08, only `out2_o` of the output pins is high, the status register reads 0xB0 (DCD, DSR and CTS levels set, no change flags), and `irq_o` is low.
- R2: Status bits 7:4 hold the synchronized levels of DCD (bit 7), RI (bit 6), DSR (bit 5) and CTS (bit 4). A pin change is visible `SYNC_STAGES`+1 clock edges after it is applied.
- R3: A change in either direction on CTS, DSR or DCD sets status bit 0, bit 1 or bit 3 respectively.
- R4: Status bit 2 is set when RI falls from 1 to 0, and never when RI rises.
- R5: Change flags are sticky. Further changes OR into them, and they stay set until a status read clears them.
- R6: Outside loopback, a status read (`reg_sel`=1) returns the current value and clears bits 3:0 at that clock edge. A change detected at the same edge is still recorded.
- R7: A control write (`reg_sel`=0) stores `wr_data[4:0]`: DTR at bit 0, RTS at bit 1, OUT1 at bit 2, OUT2 at bit 3 and loopback at bit 4. A control read returns these bits, with bits 7:5 reading as zero.
- R8: A control write with bit 4 clear copies bits 3:0 to `dtr_o`, `rts_o`, `out1_o` and `out2_o`. A control write with bit 4 set leaves all four pins unchanged.
- R9: With loopback set, a status read returns OUT2 in bit 7, OUT1 in bit 6, DTR in bit 5 and RTS in bit 4, with bits 3:0 as zero, and does not clear the change flags.
- R10: `irq_o` is high exactly when at least one change flag is set.
- R11: Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a status read clears the change flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| ri_i | input | 1 | Ring input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| irq_o | output | 1 | Modem-status interrupt source |

## Verification
The bench drives every ordered pair of the sixteen input patterns. For each pair it checks the flag byte, then reads again to confirm the clear. This exposes a design that flags a rising RI, loses a flag in one direction, or fails to clear on a read. It sweeps all 32 control values, with the upper write bits forced high. That finds a wrong loopback cross-wiring, output pins that follow a write while loopback is set, and garbage in the unused upper bits. Two further cases target flag handling: a loopback read must leave pending flags in place, and a pin that toggles and returns must leave its flag set. A design that clears the flags on a loopback read, or recomputes them from the levels, fails one of these.

// File: rtl/modem_ctl_status.sv
`timescale 1ns/1ps
module modem_ctl_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       irq_o
);
  localparam logic [3:0] LINE_RST = 4'b1011;
  localparam logic [4:0] CTL_RST  = 5'b01000;

  logic [3:0] pins_raw;
  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] smp_w;
  logic [3:0] line_q, delta_q, drive_q;
  logic [4:0] ctl_q;
  logic       loop_w, stat_rd, ctl_wr;
  logic [3:0] flip_w, new_delta;
  logic [3:0] loop_nib;

  assign pins_raw = {dcd_i, ri_i, dsr_i, cts_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= LINE_RST;
    end else begin
      sync_q[0] <= pins_raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign smp_w     = sync_q[SYNC_STAGES-1];
  assign loop_w    = ctl_q[4];
  assign stat_rd   = rd_en & reg_sel & ~loop_w;
  assign ctl_wr    = wr_en & ~reg_sel;
  assign flip_w    = line_q ^ smp_w;
  assign new_delta = {flip_w[3], line_q[2] & ~smp_w[2], flip_w[1], flip_w[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= LINE_RST;
      delta_q <= '0;
    end else begin
      line_q  <= smp_w;
      delta_q <= (stat_rd ? 4'h0 : delta_q) | new_delta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RST;
      drive_q <= CTL_RST[3:0];
    end else if (ctl_wr) begin
      ctl_q <= wr_data[4:0];
      if (!wr_data[4]) drive_q <= wr_data[3:0];
    end
  end

  assign loop_nib = {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]};

  always_comb begin
    if (!reg_sel)    rd_data = {3'b000, ctl_q};
    else if (loop_w) rd_data = {loop_nib, 4'h0};
    else             rd_data = {line_q, delta_q};
  end

  assign dtr_o  = drive_q[0];
  assign rts_o  = drive_q[1];
  assign out1_o = drive_q[2];
  assign out2_o = drive_q[3];
  assign irq_o  = |delta_q;
endmodule

// File: rtl/modem_ctl_status_chk.sv
`timescale 1ns/1ps
module modem_ctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       irq_o,
  input logic [3:0] line_q,
  input logic [3:0] smp_w,
  input logic [3:0] delta_q,
  input logic       loop_w,
  input logic [3:0] pins_o
);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && !loop_w && line_q == smp_w) |=> delta_q == 4'h0);

  a_r4_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q[2] && smp_w[2] && !delta_q[2]) |=> !delta_q[2]);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && reg_sel && !loop_w) |=> (delta_q & $past(delta_q)) == $past(delta_q));

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(line_q) != line_q);

  a_r8_loop_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && wr_data[4]) |=> $stable(pins_o));
endmodule

bind modem_ctl_status modem_ctl_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .reg_sel(reg_sel), .wr_en(wr_en),
  .wr_data(wr_data), .irq_o(irq_o), .line_q(line_q), .smp_w(smp_w),
  .delta_q(delta_q), .loop_w(loop_w), .pins_o({out2_o, out1_o, rts_o, dtr_o})
);

// File: tb/modem_ctl_status_tb.sv
`timescale 1ns/1ps
module modem_ctl_status_tb_top;
  logic clk = 0, rst_n = 0, reg_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic cts = 1, dsr = 1, ri = 0, dcd = 1;
  logic dtr, rts, out1, out2, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_ctl_status dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .cts_i(cts), .dsr_i(dsr), .ri_i(ri),
    .dcd_i(dcd), .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    reg_sel = s; rd_en = 1;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    reg_sel = s; wr_en = 1; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_pins(input logic [3:0] n);
    {dcd, ri, dsr, cts} = n;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic [3:0] exp_d, drv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(1'b1, d); check("R1 status", d, 8'hB0);
    rd(1'b0, d); check("R1 control", d, 8'h08);
    check("R1 pins", {4'h0, out2, out1, rts, dtr}, 8'h08);
    check("R1 irq", {7'h0, irq}, 8'h0);

    // R2 R3 R4 R6 R10 all ordered pairs of input levels
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_pins(a[3:0]);
        rd(1'b1, d);
        set_pins(b[3:0]);
        exp_d = (a[3:0] ^ b[3:0]) & 4'b1011;
        exp_d[2] = a[2] & ~b[2];
        check("R10 irq", {7'h0, irq}, {7'h0, exp_d != 0});
        rd(1'b1, d); check("R2/R3/R4 flags", d, {b[3:0], exp_d});
        rd(1'b1, d); check("R6 cleared", d, {b[3:0], 4'h0});
      end
    end

    // R5 accumulation
    set_pins(4'b1011); rd(1'b1, d);
    set_pins(4'b1010); set_pins(4'b1000); set_pins(4'b1001);
    rd(1'b1, d); check("R5 sticky", d, 8'h93);
    set_pins(4'b1011); rd(1'b1, d);

    // R7 R8 R9 control sweep
    drv = 4'b1000;
    for (int v = 0; v < 32; v++) begin
      wr(1'b0, 8'hE0 | 8'(v));
      rd(1'b0, d); check("R7 control", d, 8'(v));
      if (!v[4]) drv = v[3:0];
      check("R8 pins", {4'h0, out2, out1, rts, dtr}, {4'h0, drv});
      rd(1'b1, d);
      if (v[4]) check("R9 loop map", d, {v[3], v[2], v[0], v[1], 4'h0});
      else      check("R2 status", d, 8'hB0);
    end

    // R9 loop read keeps flags
    set_pins(4'b1010);
    check("R10 irq loop", {7'h0, irq}, 8'h1);
    rd(1'b1, d); check("R9 loop map", d, 8'hF0);
    wr(1'b0, 8'h00);
    rd(1'b1, d); check("R9 no clear", d, 8'hA1);

    // R11 status write ignored
    wr(1'b1, 8'h5A);
    rd(1'b1, d); check("R11 status", d, 8'hA0);
    rd(1'b0, d); check("R11 control", d, 8'h00);
    check("R11 irq", {7'h0, irq}, 8'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule